// File: doc/BRIEF.md
# Single-entry bypass queue

This block is a one-slot queue that sits between a producer and a consumer. It holds at most one word, kept in a data register and marked by one occupancy flag. Its distinguishing property is bypass. Within a cycle, the operations take effect in this order: the write, then the peek at the head, then the read, then the flush. As a result, an empty slot can hand a word that arrives in a cycle straight to the consumer in that same cycle, and the word is never stored.

The producer offers a word with a valid strobe and sees a ready signal. The consumer sees a head-available signal and the head word, and pops with a read enable. A synchronous flush input empties the slot. The flush acts last in the cycle, so a pop granted in the flush cycle still delivers its word. A write offered in the flush cycle is discarded. The data width is a parameter.

Top module: `bypass_fifo1`

## Requirements
- R1: After a synchronous active-high reset the slot is empty: `in_ready` is 1 and `out_avail` is 0 while `in_valid` is 0.
- R2: `in_ready` is 1 exactly when the slot is empty. It does not depend on `out_pop` or `flush` in the same cycle.
- R3: `out_avail` is 1 when the slot is occupied, or when it is empty and `in_valid` is 1.
- R4: `out_data` shows the stored word when the slot is occupied. It shows `in_data` when the slot is empty and `in_valid` is 1.
- R5: When the slot is empty and `in_valid` and `out_pop` are both 1, the incoming word is delivered in that cycle and the slot is still empty after the edge.
- R6: An accepted write without a pop, when `flush` is 0, fills the slot with that word at the edge.
- R7: When the slot is occupied, a pop without an accepted write (and `flush` 0) empties the slot at the edge.
- R8: A write offered while the slot is occupied is ignored. The stored word and the occupancy are unchanged if no pop occurs.
- R9: `flush` empties the slot at the edge, whatever the other inputs are. A pop granted in the same cycle still reads the word, and a write in the same cycle is lost.
- R10: `out_pop` while `out_avail` is 0 has no effect. The slot stays empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous clear, ordered last |
| in_valid | input | 1 | Producer offers a word |
| in_data | input | W | Offered word |
| in_ready | output | 1 | Slot can accept a word |
| out_avail | output | 1 | A head word is available |
| out_data | output | W | Head word (stored or bypassed) |
| out_pop | input | 1 | Consumer removes the head word |

## Verification
A write and a read can both take effect in one cycle only when the slot starts the cycle empty: the word passes straight through. This is provoked by driving `in_valid` and `out_pop` together on an empty slot. It is judged on two things: `out_data` must equal `in_data` before the edge, and `in_ready` must still be 1 after the edge, showing the slot was not left occupied. Flush paired with a pop, and with a rejected write, is also driven on an occupied slot. The bench then checks that the word is delivered and that the slot is empty afterwards. Random traffic is compared against a one-slot reference model that applies the same ordering.

// File: rtl/bypass_fifo1_pkg.sv
package bypass_fifo1_pkg;
  // Per-cycle granted operations, decided by the control stage.
  typedef struct packed {
    logic wr_fire;
    logic rd_fire;
    logic flush;
  } bf_ops_t;
endpackage

// File: rtl/bf_ctrl.sv
module bf_ctrl
  import bypass_fifo1_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    flush,
  input  logic    in_valid,
  input  logic    out_pop,
  output logic    occupied,
  output logic    in_ready,
  output logic    out_avail,
  output bf_ops_t ops
);
  logic occ_q;
  logic occ_d;

  // Write is guarded on the state at the start of the cycle only.
  assign in_ready     = ~occ_q;
  assign ops.wr_fire  = in_valid & ~occ_q;
  // The head is visible if stored, or if it is arriving right now.
  assign out_avail    = occ_q | ops.wr_fire;
  assign ops.rd_fire  = out_pop & out_avail;
  assign ops.flush    = flush;

  always_comb begin
    occ_d = (occ_q | ops.wr_fire) & ~ops.rd_fire;
    if (ops.flush) occ_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) occ_q <= 1'b0;
    else     occ_q <= occ_d;
  end

  assign occupied = occ_q;
endmodule

// File: rtl/bf_store.sv
module bf_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] slot_q;

  // Plain data register, no reset: occupancy lives in the control stage.
  always_ff @(posedge clk) begin
    if (load) slot_q <= din;
  end

  assign dout = slot_q;
endmodule

// File: rtl/bf_head_mux.sv
module bf_head_mux #(
  parameter int W = 8
) (
  input  logic         occupied,
  input  logic [W-1:0] stored,
  input  logic [W-1:0] incoming,
  output logic [W-1:0] head
);
  assign head = occupied ? stored : incoming;
endmodule

// File: rtl/bypass_fifo1.sv
module bypass_fifo1
  import bypass_fifo1_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_avail,
  output logic [W-1:0] out_data,
  input  logic         out_pop
);
  bf_ops_t      ops;
  logic         occupied;
  logic [W-1:0] stored;
  logic         load;

  bf_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .in_valid (in_valid),
    .out_pop  (out_pop),
    .occupied (occupied),
    .in_ready (in_ready),
    .out_avail(out_avail),
    .ops      (ops)
  );

  // Only capture when the word will still be resident after the edge.
  assign load = ops.wr_fire & ~ops.rd_fire & ~ops.flush;

  bf_store #(.W(W)) u_store (
    .clk (clk),
    .load(load),
    .din (in_data),
    .dout(stored)
  );

  bf_head_mux #(.W(W)) u_mux (
    .occupied(occupied),
    .stored  (stored),
    .incoming(in_data),
    .head    (out_data)
  );
endmodule

// File: rtl/bypass_fifo1_chk.sv
module bypass_fifo1_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         flush,
  input logic         in_valid,
  input logic [W-1:0] in_data,
  input logic         in_ready,
  input logic         out_avail,
  input logic [W-1:0] out_data,
  input logic         out_pop
);
  // R3 / R4: an accepted write on an empty slot is visible at the head now.
  a_r4_bypass_head: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |-> (out_avail && out_data == in_data));

  // R5: write plus pop on an empty slot leaves it empty.
  a_r5_pass_through: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && out_pop && !flush) |=> in_ready);

  // R6: lone accepted write fills the slot with that word.
  a_r6_capture: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !out_pop && !flush) |=>
      (!in_ready && out_avail && out_data == $past(in_data)));

  // R7: pop on an occupied slot empties it.
  a_r7_drain: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && out_pop && !flush) |=> in_ready);

  // R8: occupied, no pop, no flush: held word and occupancy are kept.
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !out_pop && !flush) |=> (!in_ready && $stable(out_data)));

  // R9: flush always leaves the slot empty.
  a_r9_flush_empty: assert property (@(posedge clk) disable iff (rst)
    flush |=> in_ready);

  // R10: pop with nothing available does not change emptiness.
  a_r10_idle_pop: assert property (@(posedge clk) disable iff (rst)
    (out_pop && !out_avail) |=> in_ready);
endmodule

bind bypass_fifo1 bypass_fifo1_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .flush    (flush),
  .in_valid (in_valid),
  .in_data  (in_data),
  .in_ready (in_ready),
  .out_avail(out_avail),
  .out_data (out_data),
  .out_pop  (out_pop)
);

// File: tb/bypass_fifo1_bench.sv
module bypass_fifo1_bench;
  localparam int  W        = 8;
  localparam time CLK_PER  = 10;
  localparam int  NVEC     = 16;
  localparam int  NRAND    = 400;

  // Vector: [20] flush [19] in_valid [18] out_pop [17:10] in_data
  //         [9] exp in_ready [8] exp out_avail [7:0] exp out_data
  localparam logic [20:0] VEC [NVEC] = '{
    {3'b000, 8'h00, 2'b10, 8'h00},  // 0  R1 idle empty
    {3'b010, 8'hA5, 2'b11, 8'hA5},  // 1  R3 R4 R6 write fills
    {3'b010, 8'h3C, 2'b01, 8'hA5},  // 2  R2 R8 write refused
    {3'b001, 8'h00, 2'b01, 8'hA5},  // 3  R7 pop drains
    {3'b011, 8'h5A, 2'b11, 8'h5A},  // 4  R5 pass-through
    {3'b000, 8'h00, 2'b10, 8'h00},  // 5  R5 still empty
    {3'b001, 8'h00, 2'b10, 8'h00},  // 6  R10 pop on empty
    {3'b000, 8'h00, 2'b10, 8'h00},  // 7  R10 still empty
    {3'b010, 8'hC3, 2'b11, 8'hC3},  // 8  R6 fill
    {3'b100, 8'h00, 2'b01, 8'hC3},  // 9  R2 R9 flush while full
    {3'b000, 8'h00, 2'b10, 8'h00},  // 10 R9 emptied
    {3'b110, 8'h11, 2'b11, 8'h11},  // 11 R9 flush beats write
    {3'b000, 8'h00, 2'b10, 8'h00},  // 12 R9 write lost
    {3'b010, 8'h77, 2'b11, 8'h77},  // 13 R6 fill
    {3'b111, 8'h88, 2'b01, 8'h77},  // 14 R9 pop before flush
    {3'b000, 8'h00, 2'b10, 8'h00}   // 15 R9 emptied
  };

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R1";   1: return "R6";   2: return "R8";   3: return "R7";
      4: return "R5";   5: return "R5";   6: return "R10";  7: return "R10";
      8: return "R6";   9: return "R9";   10: return "R9";  11: return "R9";
      12: return "R9";  13: return "R6";  14: return "R9";  default: return "R9";
    endcase
  endfunction

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         flush = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         out_pop = 1'b0;
  logic         in_ready;
  logic         out_avail;
  logic [W-1:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  bypass_fifo1 #(.W(W)) u_bypass_fifo1 (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_avail(out_avail),
    .out_data(out_data), .out_pop(out_pop)
  );

  task automatic check(input string tag, input logic er, input logic ea,
                       input logic [W-1:0] ed);
    n_chk++;
    if (in_ready !== er || out_avail !== ea || (ea && out_data !== ed)) begin
      n_bad++;
      $display("FAIL %s: got rdy=%b avail=%b data=%h, expected rdy=%b avail=%b data=%h",
               tag, in_ready, out_avail, out_data, er, ea, ed);
    end
  endtask

  // Drive after the falling edge, look 1 time unit later, then let the edge pass.
  task automatic apply(input logic f, input logic v, input logic p,
                       input logic [W-1:0] d);
    @(negedge clk);
    flush = f; in_valid = v; out_pop = p; in_data = d;
    #1;
  endtask

  initial begin
    #(CLK_PER * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic         m_full;
    logic [W-1:0] m_val;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17:10]);
      check(vec_tag(i), VEC[i][9], VEC[i][8], VEC[i][7:0]);
    end

    // R1: reset while occupied returns to empty
    apply(1'b0, 1'b1, 1'b0, 8'hE1);
    @(negedge clk); in_valid = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0; #1;
    check("R1", 1'b1, 1'b0, 8'h00);

    // R3 R4 R5 R6 R7 R8 R9 R10: random traffic against a one-slot model
    m_full = 1'b0; m_val = '0;
    for (int k = 0; k < NRAND; k++) begin
      logic f, v, p, er, ea, wf, rf;
      logic [W-1:0] d, ed;
      f = ($urandom_range(0, 9) == 0);
      v = $urandom_range(0, 1);
      p = $urandom_range(0, 1);
      d = W'($urandom);
      apply(f, v, p, d);
      er = ~m_full;
      wf = v & er;
      ea = m_full | wf;
      ed = m_full ? m_val : d;
      rf = p & ea;
      check("R4", er, ea, ed);
      if (f) m_full = 1'b0;
      else begin
        if (wf && !rf) m_val = d;
        m_full = (m_full | wf) & ~rf;
      end
    end

    done = 1'b1;
    @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule